// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point operands in the standard single-precision layout: sign in bit 31, an 8-bit exponent biased by 127 in bits 30..23, and a 23-bit fraction in bits 22..0. Stored exponents 1 to 254 carry a hidden leading one. Exponent 0 holds zeros and denormals, which have no hidden bit and are weighted as exponent -126. Exponent 255 holds infinities (fraction zero) and NaNs (fraction non-zero). A `op_sub` input selects subtraction, which flips the sign of the second operand before the effective operation is chosen.

The datapath has five steps. The operands are unpacked. The exponents are subtracted and the operands are swapped so that the larger magnitude sits on the wide path. The smaller significand is shifted right and keeps guard, round and sticky bits. The magnitudes are added or subtracted. Finally the result is normalized: a carry-out moves it right by one, and a leading-zero count moves it left. The result is then rounded to nearest with ties to even, checked for overflow and packed. The result and three status flags are registered.

A two-state pipeline controller holds `ST_EMPTY` and `ST_FULL`. The accept transition (`in_valid` high) goes from either state to `ST_FULL`. The drain transition (`in_valid` low) goes from either state to `ST_EMPTY`. `out_valid` is high exactly in `ST_FULL`.

Top module: `fp_addsub`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. After reset it is low, and `result` and the flags are zero.
- R2: For finite operands whose result is finite, `result` is the exact sum `opa + opb` (or `opa - opb` when `op_sub` is 1), rounded to nearest with ties to even. For example, 0x3F000000 minus 0x3EE00000 gives 0x3D800000.
- R3: When the rounded exponent of a finite result would reach 255, `result` is an infinity carrying the sign of the larger-magnitude operand (exponent 255, fraction 0) and `flag_ovf` is 1. Otherwise `flag_ovf` is 0.
- R4: When either operand is a NaN, `result` is the canonical quiet NaN 0x7FC00000.
- R5: An infinity combined with an infinity of the opposite effective sign gives 0x7FC00000 with `flag_inv` set to 1. In every other case `flag_inv` is 0.
- R6: An infinity combined with a finite value, or with an infinity of the same effective sign, gives that infinity with its effective sign.
- R7: An exact cancellation of non-zero values gives +0 (0x00000000). When both operands are zero, the sign of the result is the AND of the two effective signs.
- R8: Denormal operands are taken with no hidden bit and exponent -126. A non-zero result below the normal range is packed with exponent field 0. `flag_unf` is 1 exactly when the packed result has exponent 0 and a non-zero fraction.
- R9: With `op_sub` = 1 the second operand's sign bit is inverted before the operation. An effective subtraction happens when the first sign and the effective second sign differ.
- R10: While `in_valid` is low, `result` and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and operation are valid this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract second operand |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| out_valid | output | 1 | Result registers hold a new result |
| result | output | 32 | Packed rounded result |
| flag_ovf | output | 1 | Overflow to infinity |
| flag_unf | output | 1 | Result is denormal and non-zero |
| flag_inv | output | 1 | Invalid operation (opposite infinities) |

## Verification
The operand pairs come from four families. Fully random words cover NaN and infinity encodings and exponent gaps that push the smaller operand entirely into the sticky bit. Pairs that differ only in their low fraction bits, with random sign, cause deep cancellation; these tell apart a wrong leading-zero count, a wrong exponent decrement and the +0 rule. Pairs with tiny exponents exercise denormal inputs and outputs and the underflow flag. Pairs near the top exponent separate the carry-out path, the round-up carry and overflow. Directed cases pin the worked cancellation example, signed zeros, opposite infinities, and the hold of results while no input is offered.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } pipe_state_t;

    localparam int GRS_BITS = 3;
endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack #(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic [EW+FW:0] word,
    input  logic           flip,
    output logic           sgn,
    output logic [EW-1:0]  exp_eff,
    output logic [FW:0]    sig,
    output logic           is_zero,
    output logic           is_inf,
    output logic           is_nan
);
    logic [EW-1:0] ef;
    logic [FW-1:0] fr;
    logic          e_all1;
    logic          e_none;

    always_comb begin
        ef      = word[EW+FW-1:FW];
        fr      = word[FW-1:0];
        e_all1  = &ef;
        e_none  = ~|ef;
        sgn     = word[EW+FW] ^ flip;
        exp_eff = e_none ? EW'(1) : ef;
        sig     = {~e_none, fr};
        is_zero = e_none & ~|fr;
        is_inf  = e_all1 & ~|fr;
        is_nan  = e_all1 & |fr;
    end
endmodule

// File: rtl/fpa_align_add.sv
module fpa_align_add #(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic          sa,
    input  logic [EW-1:0] ea,
    input  logic [FW:0]   siga,
    input  logic          sb,
    input  logic [EW-1:0] eb,
    input  logic [FW:0]   sigb,
    output logic          big_sign,
    output logic [EW-1:0] big_exp,
    output logic [FW+fpa_pkg::GRS_BITS+1:0] sum
);
    localparam int M = FW + 1;
    localparam int X = M + fpa_pkg::GRS_BITS;
    localparam logic [X-1:0] ONE_X = X'(1);

    logic          a_big;
    logic [EW-1:0] e_sml;
    logic [FW:0]   s_big, s_sml;
    logic [EW-1:0] diff;
    logic [X-1:0]  ext, aligned, mask;
    logic          lost;
    logic          eff_sub;

    always_comb begin
        a_big    = {ea, siga} >= {eb, sigb};
        big_sign = a_big ? sa : sb;
        big_exp  = a_big ? ea : eb;
        e_sml    = a_big ? eb : ea;
        s_big    = a_big ? siga : sigb;
        s_sml    = a_big ? sigb : siga;
        diff     = big_exp - e_sml;
        ext      = {s_sml, {fpa_pkg::GRS_BITS{1'b0}}};
        if (32'(diff) >= X) begin
            aligned = '0;
            mask    = '1;
        end else begin
            aligned = ext >> diff;
            mask    = (ONE_X << diff) - ONE_X;
        end
        lost       = |(ext & mask);
        aligned[0] = aligned[0] | lost;
        eff_sub    = sa ^ sb;
        if (eff_sub)
            sum = {1'b0, s_big, {fpa_pkg::GRS_BITS{1'b0}}} - {1'b0, aligned};
        else
            sum = {1'b0, s_big, {fpa_pkg::GRS_BITS{1'b0}}} + {1'b0, aligned};
    end
endmodule

// File: rtl/fpa_norm_round.sv
module fpa_norm_round #(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic [FW+fpa_pkg::GRS_BITS+1:0] sum,
    input  logic [EW-1:0] big_exp,
    output logic [EW-1:0] exp_out,
    output logic [FW-1:0] frac_out,
    output logic          ovf
);
    localparam int M   = FW + 1;
    localparam int X   = M + fpa_pkg::GRS_BITS;
    localparam int LZW = $clog2(X + 1);
    localparam int EXW = EW + 2;
    localparam logic [EXW-1:0] E_TOP = EXW'((1 << EW) - 1);

    logic [LZW-1:0] lz;
    logic [EXW-1:0] lim, sh, e_n, e_f;
    logic [X-1:0]   n;
    logic           rnd_up;
    logic [M:0]     m;

    always_comb begin
        lz = LZW'(X);
        for (int i = 0; i < X; i++) begin
            if (sum[i]) lz = LZW'(X - 1 - i);
        end
        lim = EXW'(big_exp) - EXW'(1);
        sh  = (EXW'(lz) < lim) ? EXW'(lz) : lim;
        if (sum[X]) begin
            n   = {sum[X:2], sum[1] | sum[0]};
            e_n = EXW'(big_exp) + EXW'(1);
        end else begin
            n   = sum[X-1:0] << sh;
            e_n = EXW'(big_exp) - sh;
        end
        rnd_up   = n[2] & (n[1] | n[0] | n[3]);
        m        = {1'b0, n[X-1:3]} + (M+1)'(rnd_up);
        e_f      = m[M] ? e_n + EXW'(1) : e_n;
        ovf      = e_f >= E_TOP;
        exp_out  = (m[M] | m[M-1]) ? e_f[EW-1:0] : '0;
        frac_out = m[M] ? '0 : m[FW-1:0];
    end
endmodule

// File: rtl/fp_addsub.sv
module fp_addsub #(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           op_sub,
    input  logic [EW+FW:0] opa,
    input  logic [EW+FW:0] opb,
    output logic           out_valid,
    output logic [EW+FW:0] result,
    output logic           flag_ovf,
    output logic           flag_unf,
    output logic           flag_inv
);
    import fpa_pkg::*;

    localparam int W = EW + FW + 1;
    localparam int X = FW + 1 + GRS_BITS;
    localparam logic [EW-1:0] E_ALL1 = '1;
    localparam logic [W-1:0]  QNAN   = {1'b0, E_ALL1, 1'b1, {(FW-1){1'b0}}};

    logic [W-1:0]  words [2];
    logic [1:0]    flips;
    logic [1:0]    sg, zr, nf, nn;
    logic [EW-1:0] ex  [2];
    logic [FW:0]   sgf [2];

    assign words[0] = opa;
    assign words[1] = opb;
    assign flips    = {op_sub, 1'b0};

    for (genvar g = 0; g < 2; g++) begin : g_unpack
        fpa_unpack #(.EW(EW), .FW(FW)) u_unpack (
            .word    (words[g]),
            .flip    (flips[g]),
            .sgn     (sg[g]),
            .exp_eff (ex[g]),
            .sig     (sgf[g]),
            .is_zero (zr[g]),
            .is_inf  (nf[g]),
            .is_nan  (nn[g])
        );
    end

    logic          big_sign;
    logic [EW-1:0] big_exp;
    logic [X:0]    sum;
    logic [EW-1:0] exp_r;
    logic [FW-1:0] frac_r;
    logic          ovf_r;

    fpa_align_add #(.EW(EW), .FW(FW)) u_align (
        .sa (sg[0]), .ea (ex[0]), .siga (sgf[0]),
        .sb (sg[1]), .eb (ex[1]), .sigb (sgf[1]),
        .big_sign (big_sign), .big_exp (big_exp), .sum (sum)
    );

    fpa_norm_round #(.EW(EW), .FW(FW)) u_norm (
        .sum (sum), .big_exp (big_exp),
        .exp_out (exp_r), .frac_out (frac_r), .ovf (ovf_r)
    );

    logic [W-1:0] res_c;
    logic         ovf_c, unf_c, inv_c;

    always_comb begin
        ovf_c = 1'b0;
        unf_c = 1'b0;
        inv_c = 1'b0;
        if (nn[0] | nn[1]) begin
            res_c = QNAN;
        end else if (nf[0] & nf[1] & (sg[0] ^ sg[1])) begin
            res_c = QNAN;
            inv_c = 1'b1;
        end else if (nf[0]) begin
            res_c = {sg[0], E_ALL1, {FW{1'b0}}};
        end else if (nf[1]) begin
            res_c = {sg[1], E_ALL1, {FW{1'b0}}};
        end else if (zr[0] & zr[1]) begin
            res_c = {sg[0] & sg[1], {(W-1){1'b0}}};
        end else if (~|sum) begin
            res_c = '0;
        end else if (ovf_r) begin
            res_c = {big_sign, E_ALL1, {FW{1'b0}}};
            ovf_c = 1'b1;
        end else begin
            res_c = {big_sign, exp_r, frac_r};
            unf_c = (~|exp_r) & (|frac_r);
        end
    end

    pipe_state_t state, state_nxt;

    always_comb begin
        unique case (state)
            ST_EMPTY: state_nxt = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_nxt = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_nxt = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            flag_ovf <= 1'b0;
            flag_unf <= 1'b0;
            flag_inv <= 1'b0;
        end else if (in_valid) begin
            result   <= res_c;
            flag_ovf <= ovf_c;
            flag_unf <= unf_c;
            flag_inv <= inv_c;
        end
    end

    assign out_valid = (state == ST_FULL);
endmodule

// File: rtl/fp_addsub_checker.sv
module fp_addsub_checker #(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [EW+FW:0] opa,
    input logic           out_valid,
    input logic [EW+FW:0] result,
    input logic           flag_ovf,
    input logic           flag_unf,
    input logic           flag_inv
);
    localparam logic [EW-1:0] E_ALL1 = '1;
    localparam logic [EW+FW:0] QNAN = {1'b0, E_ALL1, 1'b1, {(FW-1){1'b0}}};

    p_valid_after_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_ovf_is_inf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_ovf) |-> (result[EW+FW-1:0] == {E_ALL1, {FW{1'b0}}}));
    p_nan_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opa[EW+FW-1:FW] == E_ALL1) && (opa[FW-1:0] != '0)) |=> (result == QNAN));
    p_inv_is_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_inv) |-> (result == QNAN));
    p_unf_denorm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_unf) |-> (result[EW+FW-1:FW] == '0 && result[FW-1:0] != '0));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flag_ovf) && $stable(flag_unf) && $stable(flag_inv)));
endmodule

bind fp_addsub fp_addsub_checker #(.EW(EW), .FW(FW)) u_chk (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .opa (opa),
    .out_valid (out_valid), .result (result),
    .flag_ovf (flag_ovf), .flag_unf (flag_unf), .flag_inv (flag_inv)
);

// File: tb/fp_addsub_bench.sv
module fp_addsub_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_sub = 1'b0;
    logic [31:0] opa = '0, opb = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_ovf, flag_unf, flag_inv;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_addsub u_fp_addsub (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .op_sub (op_sub),
        .opa (opa), .opb (opb), .out_valid (out_valid), .result (result),
        .flag_ovf (flag_ovf), .flag_unf (flag_unf), .flag_inv (flag_inv)
    );

    function automatic real to_real(input logic [31:0] x, input logic flip);
        int unsigned m;
        int ee;
        real v;
        m  = (x[30:23] == 0) ? {9'd0, x[22:0]} : {9'd0, 1'b1, x[22:0]};
        ee = (x[30:23] == 0) ? 1 : int'(x[30:23]);
        v  = real'(m) * (2.0 ** (ee - 150));
        return (x[31] ^ flip) ? -v : v;
    endfunction

    task automatic from_real(input real v, output logic [31:0] r, output logic ov, output logic un);
        logic [63:0] bits;
        longint unsigned sig, q, rem, half;
        int e, sh, ef;
        bits = $realtobits(v);
        e    = int'(bits[62:52]) - 1023;
        sig  = {11'd0, 1'b1, bits[51:0]};
        sh   = 29 + ((e < -126) ? (-126 - e) : 0);
        q    = sig >> sh;
        rem  = sig & ((64'd1 << sh) - 64'd1);
        half = 64'd1 << (sh - 1);
        if (rem > half || (rem == half && q[0])) q = q + 1;
        if (e >= -126) begin
            ef = e + 127;
            if (q[24]) begin ef = ef + 1; q = 0; end
        end else begin
            ef = q[23] ? 1 : 0;
        end
        ov = 1'b0;
        un = 1'b0;
        if (ef >= 255) begin
            r  = {bits[63], 8'hFF, 23'd0};
            ov = 1'b1;
        end else begin
            r  = {bits[63], 8'(ef), q[22:0]};
            un = (ef == 0) && (q[22:0] != 0);
        end
    endtask

    task automatic ref_model(input logic [31:0] a, input logic [31:0] b, input logic op,
                             output logic [31:0] r, output logic ov, output logic un, output logic iv);
        logic sa, sb, a_nan, b_nan, a_inf, b_inf, a_z, b_z;
        real s;
        sa = a[31]; sb = b[31] ^ op;
        a_nan = (a[30:23] == 8'hFF) && (a[22:0] != 0);
        b_nan = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        a_inf = (a[30:23] == 8'hFF) && (a[22:0] == 0);
        b_inf = (b[30:23] == 8'hFF) && (b[22:0] == 0);
        a_z   = (a[30:0] == 0);
        b_z   = (b[30:0] == 0);
        ov = 1'b0; un = 1'b0; iv = 1'b0;
        if (a_nan || b_nan) r = 32'h7FC00000;
        else if (a_inf && b_inf && (sa != sb)) begin r = 32'h7FC00000; iv = 1'b1; end
        else if (a_inf) r = {sa, 8'hFF, 23'd0};
        else if (b_inf) r = {sb, 8'hFF, 23'd0};
        else if (a_z && b_z) r = {sa & sb, 31'd0};
        else begin
            s = to_real(a, 1'b0) + to_real(b, op);
            if (s == 0.0) r = 32'd0;
            else from_real(s, r, ov, un);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic op, input string req);
        logic [31:0] er;
        logic eo, eu, ei;
        ref_model(a, b, op, er, eo, eu, ei);
        opa = a; opb = b; op_sub = op; in_valid = 1'b1;
        @(negedge clk);
        n_tests++;
        if (!out_valid || result !== er || flag_ovf !== eo || flag_unf !== eu || flag_inv !== ei) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h sub=%0d: got v=%0d r=%h o%0d u%0d i%0d, expected v=1 r=%h o%0d u%0d i%0d",
                     req, a, b, op, out_valid, result, flag_ovf, flag_unf, flag_inv, er, eo, eu, ei);
        end
    endtask

    task automatic check_val(input logic [31:0] got, input logic [31:0] exp, input string req);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        // R1: reset state
        check_val({31'd0, out_valid}, 32'd0, "R1 reset out_valid");
        check_val(result, 32'd0, "R1 reset result");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: worked cancellation example
        run_op(32'h3F000000, 32'h3EE00000, 1'b1, "R2 example");
        check_val(result, 32'h3D800000, "R2 example value");
        // R9: subtract of a negative becomes an add
        run_op(32'h3F800000, 32'hBF800000, 1'b1, "R9 sub neg");
        check_val(result, 32'h40000000, "R9 value");
        // R3: overflow
        run_op(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, "R3 overflow");
        check_val({31'd0, flag_ovf}, 32'd1, "R3 flag");
        run_op(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, "R3 neg overflow");
        // R4: NaN propagation
        run_op(32'h7F800001, 32'h3F800000, 1'b0, "R4 nan a");
        run_op(32'h3F800000, 32'hFFC12345, 1'b1, "R4 nan b");
        // R5: opposite infinities
        run_op(32'h7F800000, 32'h7F800000, 1'b1, "R5 inf-inf");
        check_val({31'd0, flag_inv}, 32'd1, "R5 flag");
        // R6: infinities
        run_op(32'hFF800000, 32'h3F800000, 1'b0, "R6 -inf+1");
        run_op(32'h3F800000, 32'h7F800000, 1'b1, "R6 1-inf");
        run_op(32'h7F800000, 32'h7F800000, 1'b0, "R6 inf+inf");
        // R7: zeros
        run_op(32'h40490FDB, 32'h40490FDB, 1'b1, "R7 x-x");
        check_val(result, 32'h00000000, "R7 +0");
        run_op(32'h80000000, 32'h80000000, 1'b0, "R7 -0+-0");
        check_val(result, 32'h80000000, "R7 -0");
        run_op(32'h80000000, 32'h00000000, 1'b0, "R7 -0++0");
        // R8: denormals
        run_op(32'h00000001, 32'h00000001, 1'b0, "R8 min+min");
        check_val(result, 32'h00000002, "R8 value");
        run_op(32'h00800000, 32'h00000001, 1'b1, "R8 norm-denorm");
        run_op(32'h007FFFFF, 32'h00000001, 1'b0, "R8 denorm to normal");
        // R2: tie to even
        run_op(32'h4B800000, 32'h3F800000, 1'b0, "R2 tie even");

        // R10: hold while idle
        held = result;
        in_valid = 1'b0;
        opa = 32'h3F800000; opb = 32'h3F800000;
        @(negedge clk);
        check_val({31'd0, out_valid}, 32'd0, "R1 idle out_valid");
        @(negedge clk);
        check_val(result, held, "R10 hold");

        // random mix
        for (int i = 0; i < 6000; i++) begin
            logic [31:0] a, b;
            int kind;
            a = $urandom;
            b = $urandom;
            kind = i % 4;
            if (kind == 1) begin
                b = {$urandom_range(1, 0) == 1, a[30:8], 8'($urandom)};
                if ($urandom_range(1, 0) == 1) b[8] = ~b[8];
            end else if (kind == 2) begin
                a[30:26] = 5'd0; b[30:26] = 5'd0;
                if ($urandom_range(1, 0) == 1) a[25:23] = 3'd0;
            end else if (kind == 3) begin
                a[30:24] = 7'h7F; b[30:25] = 6'h3F;
                if (a[30:23] == 8'hFF) a[23] = 1'b0;
                if (b[30:23] == 8'hFF) b[23] = 1'b0;
            end
            run_op(a, b, 1'($urandom), "R2 random");
        end
        in_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule